// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block sits between a processor load/store port and a word-wide memory port. It keeps 8 KB of data in two ways of 512 sets, with 8-byte blocks of two 32-bit words. Both ways are looked up in parallel, and a read that hits is answered combinationally in the cycle it is presented. A read that misses stalls the processor. The block then fetches both words of the block one at a time, installs them in a victim way, and completes the access as an ordinary hit.

Stores always reach memory through a single-entry write buffer. A store that hits also updates the cached word. A store that misses leaves the array untouched. A store stalls only when the buffer still holds an earlier store. The buffer is always emptied before a refill read is sent, so a refill can never fetch a value that is older than a store already accepted.

The processor holds its request (address, data, write flag) steady for as long as the stall output is high. An access completes at the rising edge where the request is high and the stall is low.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid and the write buffer is empty. The stall is low and there is no memory request while the processor is idle. The first read of any address misses.
- R2: Address bits [11:3] select the set, bits [31:12] form the tag, and bit 2 selects the word within the block. Two blocks whose tags differ and that share a set can be held at the same time, one per way, and at most one way hits.
- R3: A read hit returns the addressed word in the same cycle with the stall low and issues no memory read.
- R4: A read miss raises the stall and issues exactly two memory reads: word 0 of the block first, then word 1. It then returns the addressed word. The stall stays high while any refill read is outstanding.
- R5: On a fill, an invalid way of the set is chosen first, way 0 before way 1. When both ways are valid, a free-running pseudorandom bit with a reset seed picks the victim, and the other block stays resident.
- R6: A write hit updates the cached word, so a later read hit returns the new value. The word is also written to memory at the full store address.
- R7: A write miss does not allocate. Both blocks already resident in the set still hit afterwards, and a later read of the written address misses. The word reaches memory.
- R8: A store accepted while the buffer is empty completes with no stall. A store presented while the buffer is full stalls until the buffer has been accepted by memory. The buffered store is held stable on the memory port until it is accepted.
- R9: No refill read is issued while the write buffer is occupied. A read that misses on an address just stored returns the stored value.
- R10: A read hit is answered without stall in the same cycle that the write buffer drains to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWData | input | 32 | Store data |
| cpuRData | output | 32 | Load data, valid in the cycle the load completes |
| cpuStall | output | 1 | Processor must hold its request |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWe | output | 1 | 1 = write request, 0 = read request |
| memReqAddr | output | 32 | Word address of the memory request |
| memReqWData | output | 32 | Write data of the memory request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response data |

## Verification
The write buffer drain and a processor read hit are two separate functions that can fall in the same cycle. The bench sets this up by storing to a resident word and then presenting a load of that same word on the very next cycle, with memory ready. It judges the overlap from three observations: the load must see no stall, it must return the newly stored value, and the memory model must record the write handshake in the cycle number at which the load completed. The case where a drain must come before a refill is provoked the same way, using a store that misses followed at once by a load of that address.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  localparam int NUM_WAYS = 2;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic memRead;     // refill read owns the memory port
    logic rspCapture;  // store a refill word into the line buffer
    logic fill;        // write line buffer, tag and valid into the victim way
    logic missLatch;   // remember the missing block address
    logic wbLoad;      // accept a store into the write buffer
    logic wbDrain;     // buffered store accepted by memory
  } ctrl_t;

endpackage

// File: rtl/wtc_lfsr.sv
module wtc_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rstN,
  output logic randBit
);

  logic [WIDTH-1:0] state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEED;
    end else if (state[0]) begin
      state <= (state >> 1) ^ TAPS;
    end else begin
      state <= state >> 1;
    end
  end

  assign randBit = state[0];

endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  parameter  int OFF_W  = 3,
  parameter  int IDX_W  = 9,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WSEL_W = OFF_W - BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctl,
  input  logic [WSEL_W-1:0]   refillWord,
  input  logic                victimBit,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuWData,
  input  logic [DATA_W-1:0]   memRspData,
  output logic [NUM_WAYS-1:0] hitVec,
  output logic [DATA_W-1:0]   cpuRData,
  output logic                wbValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [DATA_W-1:0]   memReqWData
);

  localparam int WPB   = 1 << WSEL_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWord;

  assign reqTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx  = cpuAddr[OFF_W +: IDX_W];
  assign reqWord = cpuAddr[BYTE_W +: WSEL_W];

  // Latched miss block and refill line buffer
  logic [BLK_W-1:0]  missBlk;
  logic [DATA_W-1:0] lineBuf [WPB];
  logic [TAG_W-1:0]  missTag;
  logic [IDX_W-1:0]  missIdx;

  assign missTag = missBlk[BLK_W-1 -: TAG_W];
  assign missIdx = missBlk[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (ctl.missLatch) missBlk <= cpuAddr[ADDR_W-1:OFF_W];
    if (ctl.rspCapture) lineBuf[refillWord] <= memRspData;
  end

  // Victim way: first invalid way, else pseudorandom
  logic [NUM_WAYS-1:0] missValid;
  logic                fillWay;

  always_comb begin
    if (!missValid[0])      fillWay = 1'b0;
    else if (!missValid[1]) fillWay = 1'b1;
    else                    fillWay = victimBit;
  end

  logic [DATA_W-1:0] wayWord [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [DATA_W-1:0] dataMem [SETS][WPB];
    logic [SETS-1:0]   validMem;
    logic              fillHere;

    assign fillHere   = ctl.fill && (fillWay == WAY_ID);
    assign hitVec[w]  = validMem[reqIdx] && (tagMem[reqIdx] == reqTag);
    assign wayWord[w] = dataMem[reqIdx][reqWord];
    assign missValid[w] = validMem[missIdx];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validMem <= '0;
      end else if (fillHere) begin
        validMem[missIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere) begin
        tagMem[missIdx] <= missTag;
        for (int k = 0; k < WPB; k++) dataMem[missIdx][k] <= lineBuf[k];
      end else if (ctl.wbLoad && hitVec[w]) begin
        dataMem[reqIdx][reqWord] <= cpuWData;
      end
    end
  end

  assign cpuRData = hitVec[1] ? wayWord[1] : wayWord[0];

  // One-entry write buffer
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else if (ctl.wbLoad) begin
      wbValid <= 1'b1;
      wbAddr  <= cpuAddr;
      wbData  <= cpuWData;
    end else if (ctl.wbDrain) begin
      wbValid <= 1'b0;
    end
  end

  assign memReqAddr  = ctl.memRead ? {missBlk, refillWord, {BYTE_W{1'b0}}} : wbAddr;
  assign memReqWData = wbData;

endmodule

// File: rtl/wtc_control.sv
module wtc_control
  import wtc_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int OFF_W  = 3,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WSEL_W = OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              anyHit,
  input  logic              wbValid,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output ctrl_t             ctl,
  output logic [WSEL_W-1:0] refillWord,
  output logic              cpuStall,
  output logic              memReqValid,
  output logic              memReqWe
);

  localparam logic [WSEL_W-1:0] LAST_WORD = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FILL} state_t;
  state_t state, stateNext;

  logic readMiss;
  logic idle;

  assign idle     = (state == ST_IDLE);
  assign readMiss = cpuReq && !cpuWe && !anyHit;

  always_comb begin
    ctl            = '0;
    ctl.memRead    = (state == ST_REQ);
    ctl.rspCapture = (state == ST_WAIT) && memRspValid;
    ctl.fill       = (state == ST_FILL);
    ctl.missLatch  = idle && readMiss && !wbValid;
    ctl.wbLoad     = idle && cpuReq && cpuWe && !wbValid;
    ctl.wbDrain    = idle && wbValid && memReqReady;
  end

  assign memReqValid = (state == ST_REQ) || (idle && wbValid);
  assign memReqWe    = (state != ST_REQ);
  assign cpuStall    = !idle || (cpuReq && cpuWe && wbValid) || readMiss;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.missLatch) stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = (refillWord == LAST_WORD) ? ST_FILL : ST_REQ;
      ST_FILL: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      refillWord <= '0;
    end else begin
      state <= stateNext;
      if (ctl.missLatch)       refillWord <= '0;
      else if (ctl.rspCapture) refillWord <= refillWord + 1'b1;
    end
  end

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          OFF_W     = 3,
  parameter int          IDX_W     = 9,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic [DATA_W-1:0] cpuRData,
  output logic              cpuStall,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWe,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);

  localparam int WSEL_W = OFF_W - $clog2(DATA_W / 8);

  ctrl_t               ctl;
  logic [WSEL_W-1:0]   refillWord;
  logic [NUM_WAYS-1:0] hitVec;
  logic                wbValid;
  logic                victimBit;

  wtc_lfsr #(.WIDTH(16), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk(clk), .rstN(rstN), .randBit(victimBit)
  );

  wtc_control #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .anyHit(|hitVec),
    .wbValid(wbValid), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .ctl(ctl), .refillWord(refillWord), .cpuStall(cpuStall),
    .memReqValid(memReqValid), .memReqWe(memReqWe)
  );

  wtc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refillWord(refillWord), .victimBit(victimBit),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .memRspData(memRspData),
    .hitVec(hitVec), .cpuRData(cpuRData), .wbValid(wbValid),
    .memReqAddr(memReqAddr), .memReqWData(memReqWData)
  );

endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuStall,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWe,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              wbValid,
  input logic [WAYS-1:0]   hitVec
);

  // R2
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R3
  read_hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && (|hitVec) |-> !cpuStall);

  // R4
  refill_stalls_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWe |-> cpuStall);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWe));

  // R8
  wb_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && !cpuStall |=> wbValid);

  // R9
  drain_before_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWe |-> !wbValid);

endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W), .WAYS(wtc_pkg::NUM_WAYS)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuStall(cpuStall),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWe(memReqWe),
  .memReqAddr(memReqAddr), .wbValid(wbValid), .hitVec(hitVec)
);

// File: tb/wtc_cache_tb.sv
module wtc_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic [31:0] cpuRData;
  logic        cpuStall;
  logic        memReqValid;
  logic        memReqReady;
  logic        memReqWe;
  logic [31:0] memReqAddr;
  logic [31:0] memReqWData;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        readyGate = 1'b1;

  always #5 clk = ~clk;
  assign memReqReady = readyGate;

  wtc_cache u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(cpuRData), .cpuStall(cpuStall),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWe(memReqWe),
    .memReqAddr(memReqAddr), .memReqWData(memReqWData),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // Memory model
  logic [31:0] shadow [int unsigned];
  int          rdCount = 0;
  int          wrCount = 0;
  int          cycleCnt = 0;
  int          lastWrCycle = -1;

  function automatic logic [31:0] memInit(logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return memInit(a);
  endfunction

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      if (memReqWe) begin
        shadow[memReqAddr] = memReqWData;
        wrCount = wrCount + 1;
        lastWrCycle = cycleCnt;
      end else begin
        memRspValid <= 1'b1;
        memRspData  <= memRead(memReqAddr);
        rdCount = rdCount + 1;
      end
    end
    cycleCnt = cycleCnt + 1;
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Called at a falling edge; returns at a falling edge after completion.
  task automatic doAccess(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int stalls,
                          output int reads, output int acc);
    int r0;
    r0 = rdCount;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = d;
    stalls = 0;
    #1;
    while (cpuStall && stalls < 500) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd  = cpuRData;
    acc = cycleCnt;
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0;
    reads = rdCount - r0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  expKind;   // 0 none, 1 memInit(addr), 2 literal
    logic [31:0] expLit;
    logic [2:0]  expReads;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1000, 32'h0, 2'd1, 32'h0,         3'd2}, // R1 R4 cold miss
    '{1'b0, 32'h0000_1004, 32'h0, 2'd1, 32'h0,         3'd0}, // R2 R3 other word
    '{1'b0, 32'h0000_1000, 32'h0, 2'd1, 32'h0,         3'd0}, // R3 hit
    '{1'b0, 32'h0000_2000, 32'h0, 2'd1, 32'h0,         3'd2}, // R5 same set, way 1
    '{1'b0, 32'h0000_1004, 32'h0, 2'd1, 32'h0,         3'd0}, // R2 both resident
    '{1'b0, 32'h0000_2004, 32'h0, 2'd1, 32'h0,         3'd0}, // R2
    '{1'b1, 32'h0000_1000, 32'h1111_2222, 2'd0, 32'h0, 3'd0}, // R6 write hit
    '{1'b0, 32'h0000_1000, 32'h0, 2'd2, 32'h1111_2222, 3'd0}, // R6 updated
    '{1'b1, 32'h0000_3000, 32'h3333_4444, 2'd0, 32'h0, 3'd0}, // R7 write miss
    '{1'b0, 32'h0000_1004, 32'h0, 2'd1, 32'h0,         3'd0}, // R7 set unchanged
    '{1'b0, 32'h0000_2000, 32'h0, 2'd1, 32'h0,         3'd0}, // R7 set unchanged
    '{1'b0, 32'h0000_3000, 32'h0, 2'd2, 32'h3333_4444, 3'd2}, // R7 no allocate
    '{1'b1, 32'h0000_5010, 32'h5555_6666, 2'd0, 32'h0, 3'd0}, // R9 store miss
    '{1'b0, 32'h0000_5010, 32'h0, 2'd2, 32'h5555_6666, 3'd2}  // R9 drain then refill
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int stalls, reads, acc, rdX, wr0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1 idle stall", {31'b0, cpuStall}, 32'd0);
    check("R1 idle memReqValid", {31'b0, memReqValid}, 32'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      doAccess(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, stalls, reads, acc);
      if (VECS[i].expKind == 2'd1) check($sformatf("vec%0d data", i), rd, memInit(VECS[i].addr));
      if (VECS[i].expKind == 2'd2) check($sformatf("vec%0d data", i), rd, VECS[i].expLit);
      check($sformatf("vec%0d memory reads", i), reads, 32'(VECS[i].expReads));
      if (VECS[i].expReads == 3'd0) check($sformatf("vec%0d stall cycles", i), stalls, 0);
    end
    // R6 R7 stores written through at full address
    check("R6 memory word", memRead(32'h0000_1000), 32'h1111_2222);
    check("R7 memory word", memRead(32'h0000_3000), 32'h3333_4444);

    // R10 drain coincides with a read hit
    doAccess(1'b1, 32'h0000_5014, 32'h7777_8888, rd, stalls, reads, acc);
    check("R6 write hit no stall", stalls, 0);
    doAccess(1'b0, 32'h0000_5014, 32'h0, rd, stalls, reads, acc);
    check("R10 read hit stall", stalls, 0);
    check("R10 read hit data", rd, 32'h7777_8888);
    check("R10 drain same cycle", lastWrCycle, acc);
    check("R6 drained word", memRead(32'h0000_5014), 32'h7777_8888);

    // R5 victim choice in set 1
    doAccess(1'b0, 32'h0000_0008, 32'h0, rd, stalls, reads, acc);
    doAccess(1'b0, 32'h0000_4008, 32'h0, rd, stalls, reads, acc);
    doAccess(1'b0, 32'h0000_8008, 32'h0, rd, stalls, reads, acc);
    check("R5 third block filled", reads, 2);
    doAccess(1'b0, 32'h0000_8008, 32'h0, rd, stalls, reads, acc);
    check("R5 new block hits", reads, 0);
    check("R5 new block data", rd, memInit(32'h0000_8008));
    doAccess(1'b0, 32'h0000_0008, 32'h0, rd, stalls, reads, rdX);
    rdX = reads;
    check("R5 old block data", rd, memInit(32'h0000_0008));
    check("R5 reads 0 or 2", {31'b0, (rdX == 0) || (rdX == 2)}, 32'd1);
    if (rdX == 0) begin
      doAccess(1'b0, 32'h0000_4008, 32'h0, rd, stalls, reads, acc);
      check("R5 exactly one survivor", reads, 2);
    end

    // R8 buffer full stalls the next store
    readyGate = 1'b0;
    doAccess(1'b1, 32'h0000_0100, 32'hAAAA_0001, rd, stalls, reads, acc);
    check("R8 empty buffer no stall", stalls, 0);
    wr0 = wrCount;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 32'h0000_0200; cpuWData = 32'hBBBB_0002;
    #1;
    check("R8 full buffer stall", {31'b0, cpuStall}, 32'd1);
    repeat (3) @(negedge clk);
    #1;
    check("R8 still stalled", {31'b0, cpuStall}, 32'd1);
    check("R8 buffered addr held", memReqAddr, 32'h0000_0100);
    check("R8 no write yet", wrCount, wr0);
    @(negedge clk);
    readyGate = 1'b1;
    stalls = 0;
    #1;
    while (cpuStall && stalls < 100) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0;
    check("R8 first store drained", memRead(32'h0000_0100), 32'hAAAA_0001);
    repeat (3) @(negedge clk);
    check("R8 second store drained", memRead(32'h0000_0200), 32'hBBBB_0002);

    finishRun();
  end

endmodule